// File: doc/BRIEF.md
# Slow-Clock Compare Timer with Snapshot Count Read

This block is a compare-match timer. It counts rising edges of one of four slow source inputs after a programmable power-of-two prescaler. The selected source, the prescaler and the counter live in a separate timer clock domain. When a prescaled tick finds the count equal to the programmed compare value, the count wraps to zero and a sticky compare flag is raised. The flag can drive an interrupt line.

Software talks to the block over a simple synchronous register bus with four word addresses: control/status, configuration, compare and counter. Software cannot read or load the live count directly. A write of any value to the counter address asks the timer domain for a snapshot, using a toggle handshake. The captured value returns through a synchronized acknowledge into a holding register. Every read of the counter address returns that holding register. A busy bit tells software when the new snapshot has arrived.

Top module: `slowtick_timer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and a read of the counter address returns zero.
- R2: The addresses are 0 for control, 1 for configuration, 2 for compare and 3 for counter. Control bit 0 is run enable, bit 1 is interrupt enable, bit 2 is the compare flag and bit 3 is capture busy. Configuration bits [1:0] select the source and bits [5:2] hold the prescale code. The compare register is 16 bits and reads back what was written.
- R3: Source select value s counts `srcIn[s]`, and the value 2'b10 picks `srcIn[2]`, the 32.768 kHz reference input. Edges on the inputs that are not selected leave the count unchanged.
- R4: With prescale code c, the count advances once for every 2^(c+1) rising edges of the selected source. For example, code 4'b0100 gives one count per 32 edges.
- R5: A prescaled tick that finds the count equal to the compare value returns the count to zero and sets the compare flag. With a compare value of zero, the flag is set on every tick and the count stays at zero.
- R6: `irq` is high exactly while the compare flag and the interrupt enable are both set. Writing 1 to control bit 2 clears the flag. Writing 0 to that bit leaves the flag as it was.
- R7: Clearing run enable stops counting and returns both the counter and the prescaler to zero. Edges that arrive while the timer is stopped are not counted.
- R8: A write to the counter address, whatever the data, captures the live count. Such a write never changes the live count.
- R9: Every read of the counter address returns the most recent captured value, and the value stays the same across repeated reads.
- R10: Capture busy reads 1 from the cycle after a capture write until the new snapshot is in the holding register. A capture write made while busy is set is ignored.
- R11: `rdData` is zero in every cycle in which `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| tmrClk | input | 1 | Timer domain clock that samples the sources and runs the counter |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| srcIn | input | 4 | Slow count sources; index 2 is the 32.768 kHz reference |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from `addr` while `rdEn` is high |
| irq | output | 1 | Interrupt request, compare flag AND interrupt enable |

## Verification
A wrong prescaler or counter state is not visible at once. It shows up at the ports only as an `irq` edge that is early, late or missing. The bench compares `irq` against a behavioural model on every clock, so a wrong state is caught six cycles after the source edge that should have caused the tick. A wrong state in the capture handshake shows as a busy bit that stays set, or as a snapshot value that differs from the model count. That difference becomes visible at the first counter read after the busy bit drops, which is about seven bus cycles after the capture write.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int unsigned CNT_W      = 16;
  localparam int unsigned DATA_W     = CNT_W;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned SRC_N      = 1 << SEL_W;
  localparam int unsigned PRE_CODE_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_CNT  = 2'd3
  } regAddr_e;

  // bus domain -> timer domain
  typedef struct packed {
    logic                  runEn;
    logic                  capTgl;
    logic [SEL_W-1:0]      srcSel;
    logic [PRE_CODE_W-1:0] divCode;
    logic [CNT_W-1:0]      cmpVal;
  } ctlStrobe_t;

  // timer domain -> bus domain
  typedef struct packed {
    logic             hitTgl;
    logic             ackTgl;
    logic [CNT_W-1:0] snapVal;
  } dpReturn_t;
endpackage

// File: rtl/stt_sync.sv
module stt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= '0;
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/stt_datapath.sv
module stt_datapath
  import stt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] srcIn,
  input  ctlStrobe_t       strobe,
  output dpReturn_t        dpRet
);
  localparam int unsigned PRE_W = 1 << PRE_CODE_W;

  logic             srcPick, srcS, srcPrev, srcRise;
  logic             runS, capS, capSeen;
  logic             hitTgl, ackTgl;
  logic [PRE_W-1:0] preCnt, preLast;
  logic [CNT_W-1:0] cnt, snap;
  logic             preWrap, cntHit;

  // selection is quasi-static: only changed while stopped
  assign srcPick = srcIn[strobe.srcSel];

  stt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_srcSync (
    .clk(clk), .rstN(rstN), .d(srcPick), .q(srcS));
  stt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_runSync (
    .clk(clk), .rstN(rstN), .d(strobe.runEn), .q(runS));
  stt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_capSync (
    .clk(clk), .rstN(rstN), .d(strobe.capTgl), .q(capS));

  // last prescaler value before wrap: 2^(code+1) - 1
  assign preLast = ~({PRE_W{1'b1}} << ({1'b0, strobe.divCode} + (PRE_CODE_W+1)'(1)));
  assign srcRise = srcS & ~srcPrev;
  assign preWrap = srcRise && (preCnt == preLast);
  assign cntHit  = (cnt == strobe.cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev <= 1'b0;
      preCnt  <= '0;
      cnt     <= '0;
      hitTgl  <= 1'b0;
    end else begin
      srcPrev <= srcS;
      if (!runS) begin
        preCnt <= '0;
        cnt    <= '0;
      end else if (srcRise) begin
        if (preWrap) begin
          preCnt <= '0;
          if (cntHit) begin
            cnt    <= '0;
            hitTgl <= ~hitTgl;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  // snapshot side of the capture handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSeen <= 1'b0;
      snap    <= '0;
      ackTgl  <= 1'b0;
    end else begin
      capSeen <= capS;
      if (capS != capSeen) begin
        snap   <= cnt;
        ackTgl <= ~ackTgl;
      end
    end
  end

  always_comb begin
    dpRet.hitTgl  = hitTgl;
    dpRet.ackTgl  = ackTgl;
    dpRet.snapVal = snap;
  end
endmodule

// File: rtl/stt_ctrl.sv
module stt_ctrl
  import stt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output ctlStrobe_t        strobe,
  input  dpReturn_t         dpRet
);
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_HIT  = 2;
  localparam int unsigned BIT_BUSY = 3;
  localparam int unsigned CFG_W    = SEL_W + PRE_CODE_W;

  regAddr_e              regSel;
  logic                  wrCtrl, wrCfg, wrCmp, wrCnt;
  logic                  runEn, irqEn, hitFlag, capBusy, capTgl;
  logic [SEL_W-1:0]      srcSel;
  logic [PRE_CODE_W-1:0] divCode;
  logic [CNT_W-1:0]      cmpVal, holdReg;
  logic                  hitS, hitSeen, hitPulse;
  logic                  ackS, ackSeen, ackPulse;

  assign regSel = regAddr_e'(addr);
  assign wrCtrl = wrEn && (regSel == ADDR_CTRL);
  assign wrCfg  = wrEn && (regSel == ADDR_CFG);
  assign wrCmp  = wrEn && (regSel == ADDR_CMP);
  assign wrCnt  = wrEn && (regSel == ADDR_CNT);

  stt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_hitSync (
    .clk(clk), .rstN(rstN), .d(dpRet.hitTgl), .q(hitS));
  stt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ackSync (
    .clk(clk), .rstN(rstN), .d(dpRet.ackTgl), .q(ackS));

  assign hitPulse = hitS ^ hitSeen;
  assign ackPulse = ackS ^ ackSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      irqEn   <= 1'b0;
      hitFlag <= 1'b0;
      hitSeen <= 1'b0;
      ackSeen <= 1'b0;
      srcSel  <= '0;
      divCode <= '0;
      cmpVal  <= '0;
    end else begin
      hitSeen <= hitS;
      ackSeen <= ackS;
      if (wrCtrl) begin
        runEn <= wrData[BIT_RUN];
        irqEn <= wrData[BIT_IE];
      end
      // a new hit wins over a simultaneous clear
      hitFlag <= hitPulse | (hitFlag & ~(wrCtrl & wrData[BIT_HIT]));
      if (wrCfg) begin
        srcSel  <= wrData[SEL_W-1:0];
        divCode <= wrData[CFG_W-1:SEL_W];
      end
      if (wrCmp) cmpVal <= wrData[CNT_W-1:0];
    end
  end

  // request side of the capture handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capTgl  <= 1'b0;
      capBusy <= 1'b0;
      holdReg <= '0;
    end else if (wrCnt && !capBusy) begin
      capTgl  <= ~capTgl;
      capBusy <= 1'b1;
    end else if (ackPulse) begin
      capBusy <= 1'b0;
      holdReg <= dpRet.snapVal;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (regSel)
        ADDR_CTRL: begin
          rdData[BIT_RUN]  = runEn;
          rdData[BIT_IE]   = irqEn;
          rdData[BIT_HIT]  = hitFlag;
          rdData[BIT_BUSY] = capBusy;
        end
        ADDR_CFG:  rdData[CFG_W-1:0] = {divCode, srcSel};
        ADDR_CMP:  rdData[CNT_W-1:0] = cmpVal;
        ADDR_CNT:  rdData[CNT_W-1:0] = holdReg;
        default:   rdData = '0;
      endcase
    end
  end

  assign irq = hitFlag & irqEn;

  always_comb begin
    strobe.runEn   = runEn;
    strobe.capTgl  = capTgl;
    strobe.srcSel  = srcSel;
    strobe.divCode = divCode;
    strobe.cmpVal  = cmpVal;
  end
endmodule

// File: rtl/slowtick_timer.sv
module slowtick_timer
  import stt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              tmrClk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  ctlStrobe_t strobe;
  dpReturn_t  dpRet;

  stt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(busClk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .strobe(strobe), .dpRet(dpRet));

  stt_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(tmrClk), .rstN(rstN), .srcIn(srcIn), .strobe(strobe), .dpRet(dpRet));
endmodule

// File: rtl/stt_checker.sv
module stt_checker
  import stt_pkg::*;
(
  input logic              busClk,
  input logic              tmrClk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              irq,
  input logic              capTgl,
  input logic              runEn,
  input logic              hitTgl,
  input logic              ackTgl,
  input logic [CNT_W-1:0]  snapVal
);
  // R8
  cap_from_write_chk: assert property (@(posedge busClk) disable iff (!rstN)
    !$stable(capTgl) |-> $past(wrEn && (addr == ADDR_CNT)));

  // R9
  snap_with_ack_chk: assert property (@(posedge tmrClk) disable iff (!rstN)
    !$stable(snapVal) |-> !$stable(ackTgl));

  // R7
  hit_needs_run_chk: assert property (@(posedge tmrClk) disable iff (!rstN)
    !$stable(hitTgl) |-> ($past(runEn, 1) || $past(runEn, 2) || $past(runEn, 3)));

  // R6
  irq_drop_by_write_chk: assert property (@(posedge busClk) disable iff (!rstN)
    $fell(irq) |-> $past(wrEn && (addr == ADDR_CTRL)));

  // R11
  idle_read_zero_chk: assert property (@(posedge busClk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));
endmodule

bind slowtick_timer stt_checker u_chk (
  .busClk(busClk), .tmrClk(tmrClk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .rdData(rdData), .irq(irq),
  .capTgl(strobe.capTgl), .runEn(strobe.runEn),
  .hitTgl(dpRet.hitTgl), .ackTgl(dpRet.ackTgl), .snapVal(dpRet.snapVal));

// File: tb/sim_slowtick_timer.sv
`timescale 1ns/1ps
module sim_slowtick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcIn = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;

  int total = 0, bad = 0;

  // behavioural model
  int  cyc = 0;
  int  evQ[$];
  bit  mEn = 0, mIe = 0, mFlag = 0, pSrc = 0, pWr = 0;
  int  mSel = 0, mDiv = 0, mCmp = 0, mPre = 0, mCnt = 0;
  int  pAddr = 0, pData = 0;

  always #10 clk = ~clk;

  slowtick_timer u0 (
    .busClk(clk), .tmrClk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model of flag and irq (R5, R6)
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (pWr && pAddr == 0) begin
        mIe = pData[1];
        if (pData[2]) mFlag = 0;
      end
      if (evQ.size() > 0 && evQ[0] + 6 == cyc) begin
        void'(evQ.pop_front());
        mFlag = 1;
      end
      chk("R6 irq per clock", int'(irq), int'(mFlag & mIe));
      pWr = wrEn; pAddr = addr; pData = wrData;
      if (srcIn[mSel] && !pSrc && mEn) begin
        if (mPre == (1 << (mDiv + 1)) - 1) begin
          mPre = 0;
          if (mCnt == mCmp) begin mCnt = 0; evQ.push_back(cyc); end
          else mCnt++;
        end else mPre++;
      end
      pSrc = srcIn[mSel];
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busWrite(input int a, input int d);
    @(posedge clk); #2;
    wrEn = 1; addr = 2'(a); wrData = 16'(d);
    if (a == 0) begin
      mEn = d[0];
      if (!d[0]) begin mPre = 0; mCnt = 0; end
    end else if (a == 1) begin
      mSel = d & 3; mDiv = (d >> 2) & 15;
    end else if (a == 2) mCmp = d & 16'hffff;
    @(posedge clk); #2;
    wrEn = 0;
  endtask

  task automatic busRead(input int a, output int d);
    @(posedge clk); #2;
    rdEn = 1; addr = 2'(a);
    @(negedge clk); #1;
    d = int'(rdData);
    @(posedge clk); #2;
    rdEn = 0;
  endtask

  task automatic pulses(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; srcIn[which] = 1;
      idle(1); #2; srcIn[which] = 0;
      idle(1);
    end
    idle(4);
  endtask

  task automatic capture(output int v);
    int st;
    busWrite(3, 16'hbeef);
    st = 0;
    for (int i = 0; i < 30; i++) begin
      busRead(0, st);
      if (!st[3]) break;
    end
    chk("R10 busy drops", st[3], 0);
    busRead(3, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, st;
    idle(5); #2; rstN = 1;
    idle(2);
    // R1 reset state
    busRead(0, v); chk("R1 ctrl reset", v, 0);
    busRead(1, v); chk("R1 cfg reset", v, 0);
    busRead(2, v); chk("R1 cmp reset", v, 0);
    busRead(3, v); chk("R1 R9 counter before capture", v, 0);
    chk("R1 irq reset", int'(irq), 0);
    // R11 idle bus
    @(posedge clk); #2; addr = 2'd2; @(negedge clk); #1;
    chk("R11 rdData idle", int'(rdData), 0);
    // R2 readback
    busWrite(2, 16'h1234); busRead(2, v); chk("R2 cmp readback", v, 16'h1234);
    busWrite(1, 16'h0032); busRead(1, v); chk("R2 cfg readback", v, 16'h0032);
    // R3 R4 src2, div2, cmp 3
    busWrite(1, 2); busWrite(2, 3); busWrite(0, 3); idle(4);
    busRead(0, v); chk("R2 ctrl readback", v, 3);
    pulses(2, 5);
    capture(v); chk("R4 R8 count after 5 edges", v, 2); chk("R4 model", v, mCnt);
    busRead(3, st); chk("R9 repeat read", st, 2);
    // R10 busy right after capture write
    busWrite(3, 16'h0);
    busRead(0, st); chk("R10 busy set", st[3], 1);
    busWrite(3, 16'hffff);
    idle(20);
    busRead(0, st); chk("R10 ignored write", st[3], 0);
    // R5 wrap past compare
    pulses(2, 6);
    capture(v); chk("R5 count after wrap", v, 1);
    busRead(0, st); chk("R5 flag set", st[2], 1);
    // R6 write 0 keeps, write 1 clears
    busWrite(0, 3); busRead(0, st); chk("R6 flag kept", st[2], 1);
    chk("R6 irq high", int'(irq), 1);
    busWrite(0, 7); busRead(0, st); chk("R6 flag cleared", st[2], 0);
    chk("R6 irq low", int'(irq), 0);
    // R3 unselected sources ignored
    pulses(0, 8); pulses(3, 8); pulses(1, 4);
    capture(v); chk("R3 unselected", v, 1);
    // R7 stop resets and ignores edges
    busWrite(0, 2); idle(4);
    capture(v); chk("R7 stop clears", v, 0);
    pulses(2, 6);
    capture(v); chk("R7 stopped edges", v, 0);
    // R4 divide by 32
    busWrite(1, (4 << 2) | 2); busWrite(2, 2); busWrite(0, 3); idle(4);
    pulses(2, 70);
    capture(v); chk("R4 div32 count", v, 2);
    pulses(2, 32);
    capture(v); chk("R5 div32 wrap", v, 0); chk("R5 model", v, mCnt);
    busRead(0, st); chk("R5 div32 flag", st[2], 1);
    busWrite(0, 6); idle(2); busWrite(0, 0);
    // R5 compare zero
    busWrite(2, 0); busWrite(1, 2); busWrite(0, 3); idle(4);
    pulses(2, 3);
    capture(v); chk("R5 cmp zero count", v, 0);
    busRead(0, st); chk("R5 cmp zero flag", st[2], 1);
    busWrite(0, 7); busRead(0, st); chk("R6 clear again", st[2], 0);
    // R3 source 0
    busWrite(0, 0); busWrite(1, 0); busWrite(2, 100); busWrite(0, 1); idle(4);
    pulses(0, 6); pulses(2, 6);
    capture(v); chk("R3 source 0", v, 3);
    idle(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule